// File: doc/BRIEF.md
# Crossbar Output Arbiter with Ticket Ordering and Hunt Groups

This block decides which input of a packet crossbar may connect to which physical output, and in what order. Every logical destination keeps two wrapping counters: the number to hand out next and the number now being served. An input that wants a destination draws the next number from it and then waits; when the destination's served count equals the number it holds, the input is connected. Requests to one destination are therefore served strictly in the order they were made, with no central queue.

A logical destination maps onto one or more physical outputs through a map loaded over a small configuration port. When several physical outputs share one logical address they form a hunt group: the waiting input is connected to the lowest-numbered free member, with no extra cycles against a single-port destination. An input that marks its traffic as order-sensitive is instead always steered to one fixed member, picked from its key, so a flow never spreads across members. Connections are never torn down by a command; a physical output stays taken after a connect until it signals release, and the next connect to it implicitly ends the old one. Logical address 0 is kept for the control processor and cannot be remapped.

Top module: `xta_arbiter`

## Requirements
- R1: After reset no connect is issued, no input is waiting, and every physical output p maps to logical address p.
- R2: An accepted request takes the next number of its destination; requests to the same destination accepted in one cycle are numbered by ascending input index, and connects to one destination occur in number order.
- R3: A request to a destination with a free port, driven before clock edge k, gives a connect pulse of exactly one cycle registered at edge k+1; connects to different free ports follow on consecutive cycles without any teardown cycle.
- R4: An unpinned request to a hunt group connects to the lowest-numbered member that is free.
- R5: A pinned request connects only to member (key mod member-count), members counted in ascending physical order from 0; while that member is taken the request waits even if other members are free.
- R6: A physical output is taken from its connect until a release pulse on it; a release captured at edge k lets a waiting request connect at edge k+1.
- R7: A configuration write assigns a physical output to a logical address; a write to physical output 0 or naming logical address 0 is ignored.
- R8: At most one connect is issued per cycle; when several destinations are ready, the lowest logical address wins.
- R9: A request on an input that is already waiting is ignored, and the waiting request is unchanged.
- R10: Both counters of a destination wrap modulo 2^TW (64 by default) without breaking the order of service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_IN | Per-input request strobe |
| req_dest_i | input | N_IN x LW | Per-input logical destination |
| req_pin_i | input | N_IN | Per-input order-sensitive flag |
| req_key_i | input | N_IN x KEY_W | Per-input pinning key |
| rel_i | input | N_OUT | Per-physical-output release pulse |
| cfg_we_i | input | 1 | Map write strobe |
| cfg_phys_i | input | PW | Physical output to remap |
| cfg_log_i | input | LW | Logical address to assign |
| wait_o | output | N_IN | Inputs holding an unserved number |
| gnt_valid_o | output | 1 | Connect pulse |
| gnt_in_o | output | IW | Input being connected |
| gnt_phys_o | output | PW | Physical output being connected |
| gnt_log_o | output | LW | Logical address served |

## Verification
Single requests to plain and grouped destinations separate the lowest-free choice from the pinned choice, and keys above the group size show whether the modulo is taken. Simultaneous requests to one destination, served one at a time behind a single port, reveal whether numbering follows input index; simultaneous requests to two destinations reveal the priority among destinations and the absence of a teardown gap. Holding a pinned member busy while another member is free separates pinned waiting from hunting, and a long run of round trips to one destination carries the counters through their wrap.

// File: rtl/xta_pkg.sv
package xta_pkg;

    localparam int DEF_N_IN  = 36;
    localparam int DEF_N_OUT = 36;
    localparam int DEF_N_LOG = 36;
    localparam int DEF_KEY_W = 4;

    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xta_port_map.sv
module xta_port_map #(
    parameter int N_OUT = xta_pkg::DEF_N_OUT,
    parameter int N_LOG = xta_pkg::DEF_N_LOG,
    parameter int PW    = xta_pkg::width_of(N_OUT),
    parameter int LW    = xta_pkg::width_of(N_LOG)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we_i,
    input  logic [PW-1:0]                     cfg_phys_i,
    input  logic [LW-1:0]                     cfg_log_i,
    output logic [N_LOG-1:0][N_OUT-1:0]       member_o
);

    logic [N_OUT-1:0][LW-1:0] map_q;
    logic                     wr_ok;

    assign wr_ok = cfg_we_i
                && (cfg_phys_i != '0) && (cfg_log_i != '0)
                && (int'(cfg_phys_i) < N_OUT) && (int'(cfg_log_i) < N_LOG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < N_OUT; p++) map_q[p] <= LW'(p % N_LOG);
        end else if (wr_ok) begin
            map_q[cfg_phys_i] <= cfg_log_i;
        end
    end

    always_comb begin
        for (int l = 0; l < N_LOG; l++)
            for (int p = 0; p < N_OUT; p++)
                member_o[l][p] = (int'(map_q[p]) == l);
    end

    // R7: the control processor port keeps logical address 0
    a_r7_cp_fixed: assert property (@(posedge clk) disable iff (rst)
        map_q[0] == '0);

endmodule

// File: rtl/xta_tickets.sv
module xta_tickets #(
    parameter int N_IN  = xta_pkg::DEF_N_IN,
    parameter int N_LOG = xta_pkg::DEF_N_LOG,
    parameter int TW    = $clog2(N_IN + 1),
    parameter int CW    = $clog2(N_IN + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_LOG-1:0][CW-1:0]    add_i,
    input  logic [N_LOG-1:0]            adv_i,
    output logic [N_LOG-1:0][TW-1:0]    next_o,
    output logic [N_LOG-1:0][TW-1:0]    serve_o
);

    logic [N_LOG-1:0][TW-1:0] next_q, serve_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q  <= '0;
            serve_q <= '0;
        end else begin
            for (int l = 0; l < N_LOG; l++) begin
                next_q[l]  <= next_q[l] + TW'(add_i[l]);
                serve_q[l] <= serve_q[l] + TW'(adv_i[l]);
            end
        end
    end

    assign next_o  = next_q;
    assign serve_o = serve_q;

    generate
        for (genvar l = 0; l < N_LOG; l++) begin : g_chk
            // R2/R10: served count never runs past handed-out count, even across wrap
            a_r2_serve_behind: assert property (@(posedge clk) disable iff (rst)
                int'(TW'(next_q[l] - serve_q[l])) <= N_IN);
        end
    endgenerate

endmodule

// File: rtl/xta_hunt_select.sv
module xta_hunt_select #(
    parameter int N_OUT = xta_pkg::DEF_N_OUT,
    parameter int KEY_W = xta_pkg::DEF_KEY_W,
    parameter int PW    = xta_pkg::width_of(N_OUT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_OUT-1:0]  member_i,
    input  logic [N_OUT-1:0]  free_i,
    input  logic              pin_i,
    input  logic [KEY_W-1:0]  key_i,
    output logic              ok_o,
    output logic [PW-1:0]     sel_o
);

    int           cnt, idx, seen;
    logic         found, lo_ok;
    logic [PW-1:0] tgt, lo;

    always_comb begin
        cnt = 0;
        for (int p = 0; p < N_OUT; p++) cnt = cnt + int'(member_i[p]);
        idx   = (cnt == 0) ? 0 : (int'(key_i) % cnt);
        seen  = 0;
        found = 1'b0;
        tgt   = '0;
        for (int p = 0; p < N_OUT; p++) begin
            if (member_i[p]) begin
                if (!found && seen == idx) begin
                    found = 1'b1;
                    tgt   = PW'(p);
                end
                seen = seen + 1;
            end
        end
        lo_ok = 1'b0;
        lo    = '0;
        for (int p = 0; p < N_OUT; p++) begin
            if (!lo_ok && member_i[p] && free_i[p]) begin
                lo_ok = 1'b1;
                lo    = PW'(p);
            end
        end
        if (pin_i) begin
            ok_o  = found && free_i[tgt];
            sel_o = tgt;
        end else begin
            ok_o  = lo_ok;
            sel_o = lo;
        end
    end

    // R4: a chosen port is a free member of the group
    a_r4_free_member: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> (member_i[sel_o] && free_i[sel_o]));

    // R4: unpinned choice leaves no lower free member
    a_r4_lowest_free: assert property (@(posedge clk) disable iff (rst)
        (ok_o && !pin_i) |-> ((member_i & free_i & ~({N_OUT{1'b1}} << sel_o)) == '0));

endmodule

// File: rtl/xta_arbiter.sv
module xta_arbiter #(
    parameter int N_IN  = xta_pkg::DEF_N_IN,
    parameter int N_OUT = xta_pkg::DEF_N_OUT,
    parameter int N_LOG = xta_pkg::DEF_N_LOG,
    parameter int KEY_W = xta_pkg::DEF_KEY_W,
    localparam int IW   = xta_pkg::width_of(N_IN),
    localparam int PW   = xta_pkg::width_of(N_OUT),
    localparam int LW   = xta_pkg::width_of(N_LOG),
    localparam int TW   = $clog2(N_IN + 1),
    localparam int CW   = $clog2(N_IN + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_IN-1:0]               req_valid_i,
    input  logic [N_IN-1:0][LW-1:0]       req_dest_i,
    input  logic [N_IN-1:0]               req_pin_i,
    input  logic [N_IN-1:0][KEY_W-1:0]    req_key_i,
    input  logic [N_OUT-1:0]              rel_i,
    input  logic                          cfg_we_i,
    input  logic [PW-1:0]                 cfg_phys_i,
    input  logic [LW-1:0]                 cfg_log_i,
    output logic [N_IN-1:0]               wait_o,
    output logic                          gnt_valid_o,
    output logic [IW-1:0]                 gnt_in_o,
    output logic [PW-1:0]                 gnt_phys_o,
    output logic [LW-1:0]                 gnt_log_o
);

    // waiting-request table
    logic [N_IN-1:0]               pend_q;
    logic [N_IN-1:0][LW-1:0]       dest_q;
    logic [N_IN-1:0]               pin_q;
    logic [N_IN-1:0][KEY_W-1:0]    key_q;
    logic [N_IN-1:0][TW-1:0]       tkt_q;
    logic [N_OUT-1:0]              occ_q;

    logic [N_LOG-1:0][N_OUT-1:0]   member;
    logic [N_LOG-1:0][TW-1:0]      next_tkt, serving;
    logic [N_LOG-1:0][CW-1:0]      add_cnt;
    logic [N_LOG-1:0]              adv;

    logic [N_IN-1:0]               accept;
    logic [N_IN-1:0][TW-1:0]       new_tkt;

    logic [N_LOG-1:0]              head_hit, sel_ok, ready;
    logic [N_LOG-1:0][IW-1:0]      head_in;
    logic [N_LOG-1:0][PW-1:0]      sel_phys;

    logic                          win_any;
    logic [LW-1:0]                 win_log;
    logic [IW-1:0]                 win_in;
    logic [PW-1:0]                 win_phys;

    xta_port_map #(.N_OUT(N_OUT), .N_LOG(N_LOG), .PW(PW), .LW(LW)) u_map (
        .clk(clk), .rst(rst),
        .cfg_we_i(cfg_we_i), .cfg_phys_i(cfg_phys_i), .cfg_log_i(cfg_log_i),
        .member_o(member)
    );

    xta_tickets #(.N_IN(N_IN), .N_LOG(N_LOG), .TW(TW), .CW(CW)) u_tkt (
        .clk(clk), .rst(rst),
        .add_i(add_cnt), .adv_i(adv),
        .next_o(next_tkt), .serve_o(serving)
    );

    // ticket drawing: same-cycle requests to one destination ordered by input index
    always_comb begin
        for (int i = 0; i < N_IN; i++)
            accept[i] = req_valid_i[i] && !pend_q[i] && (int'(req_dest_i[i]) < N_LOG);
        for (int i = 0; i < N_IN; i++) begin
            int off;
            off = 0;
            for (int j = 0; j < i; j++)
                if (accept[j] && req_dest_i[j] == req_dest_i[i]) off = off + 1;
            new_tkt[i] = next_tkt[req_dest_i[i]] + TW'(off);
        end
        for (int l = 0; l < N_LOG; l++) begin
            int n;
            n = 0;
            for (int i = 0; i < N_IN; i++)
                if (accept[i] && int'(req_dest_i[i]) == l) n = n + 1;
            add_cnt[l] = CW'(n);
        end
    end

    // head of line per logical destination: the input holding the served number
    always_comb begin
        for (int l = 0; l < N_LOG; l++) begin
            head_hit[l] = 1'b0;
            head_in[l]  = '0;
            for (int i = 0; i < N_IN; i++) begin
                if (!head_hit[l] && pend_q[i] && int'(dest_q[i]) == l
                    && tkt_q[i] == serving[l]) begin
                    head_hit[l] = 1'b1;
                    head_in[l]  = IW'(i);
                end
            end
        end
    end

    generate
        for (genvar l = 0; l < N_LOG; l++) begin : g_dest
            xta_hunt_select #(.N_OUT(N_OUT), .KEY_W(KEY_W), .PW(PW)) u_sel (
                .clk(clk), .rst(rst),
                .member_i(member[l]),
                .free_i(~occ_q),
                .pin_i(pin_q[head_in[l]]),
                .key_i(key_q[head_in[l]]),
                .ok_o(sel_ok[l]),
                .sel_o(sel_phys[l])
            );
            assign ready[l] = head_hit[l] && sel_ok[l];
        end
    endgenerate

    // one connect per cycle, lowest logical address first
    always_comb begin
        win_any  = 1'b0;
        win_log  = '0;
        win_in   = '0;
        win_phys = '0;
        for (int l = 0; l < N_LOG; l++) begin
            if (!win_any && ready[l]) begin
                win_any  = 1'b1;
                win_log  = LW'(l);
                win_in   = head_in[l];
                win_phys = sel_phys[l];
            end
        end
        for (int l = 0; l < N_LOG; l++)
            adv[l] = win_any && (int'(win_log) == l);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            dest_q      <= '0;
            pin_q       <= '0;
            key_q       <= '0;
            tkt_q       <= '0;
            occ_q       <= '0;
            gnt_valid_o <= 1'b0;
            gnt_in_o    <= '0;
            gnt_phys_o  <= '0;
            gnt_log_o   <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (accept[i]) begin
                    pend_q[i] <= 1'b1;
                    dest_q[i] <= req_dest_i[i];
                    pin_q[i]  <= req_pin_i[i];
                    key_q[i]  <= req_key_i[i];
                    tkt_q[i]  <= new_tkt[i];
                end else if (win_any && int'(win_in) == i) begin
                    pend_q[i] <= 1'b0;
                end
            end
            for (int p = 0; p < N_OUT; p++) begin
                if (win_any && int'(win_phys) == p) occ_q[p] <= 1'b1;
                else if (rel_i[p])                  occ_q[p] <= 1'b0;
            end
            gnt_valid_o <= win_any;
            gnt_in_o    <= win_in;
            gnt_phys_o  <= win_phys;
            gnt_log_o   <= win_log;
        end
    end

    assign wait_o = pend_q;

    // R6: a connected port is marked taken
    a_r6_port_taken: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> occ_q[gnt_phys_o]);

    // R8: a connected input no longer waits
    a_r8_input_cleared: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> !pend_q[gnt_in_o]);

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_hold
            // R9: a waiting request keeps its destination and number
            a_r9_slot_frozen: assert property (@(posedge clk) disable iff (rst)
                (pend_q[i] && $past(pend_q[i])) |-> ($stable(dest_q[i]) && $stable(tkt_q[i])));
        end
    endgenerate

endmodule

// File: tb/xta_arbiter_tb.sv
module xta_arbiter_tb_top;

    localparam int N_IN = 36, N_OUT = 36, N_LOG = 36, KEY_W = 4;
    localparam int IW = 6, PW = 6, LW = 6;

    logic                        clk = 1'b0;
    logic                        rst;
    logic [N_IN-1:0]             req_valid;
    logic [N_IN-1:0][LW-1:0]     req_dest;
    logic [N_IN-1:0]             req_pin;
    logic [N_IN-1:0][KEY_W-1:0]  req_key;
    logic [N_OUT-1:0]            rel;
    logic                        cfg_we;
    logic [PW-1:0]               cfg_phys;
    logic [LW-1:0]               cfg_log;
    logic [N_IN-1:0]             wait_v;
    logic                        gnt_valid;
    logic [IW-1:0]               gnt_in;
    logic [PW-1:0]               gnt_phys;
    logic [LW-1:0]               gnt_log;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xta_arbiter #(.N_IN(N_IN), .N_OUT(N_OUT), .N_LOG(N_LOG), .KEY_W(KEY_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_dest_i(req_dest),
        .req_pin_i(req_pin), .req_key_i(req_key),
        .rel_i(rel),
        .cfg_we_i(cfg_we), .cfg_phys_i(cfg_phys), .cfg_log_i(cfg_log),
        .wait_o(wait_v),
        .gnt_valid_o(gnt_valid), .gnt_in_o(gnt_in),
        .gnt_phys_o(gnt_phys), .gnt_log_o(gnt_log)
    );

    typedef struct packed {
        int in_i; int dest; int pin; int key; int phys;
    } vec_t;

    // hunt group: logical 5 = physical {5, 9, 12}
    localparam vec_t VEC [9] = '{
        '{3, 5, 0, 0, 5},    // R4 lowest free member
        '{7, 5, 1, 0, 5},    // R5 key 0 -> member 0
        '{7, 5, 1, 1, 9},    // R5 key 1 -> member 1
        '{7, 5, 1, 2, 12},   // R5 key 2 -> member 2
        '{7, 5, 1, 4, 9},    // R5 key 4 mod 3 = 1
        '{7, 5, 1, 15, 5},   // R5 key 15 mod 3 = 0
        '{0, 2, 0, 0, 2},    // R3 single port
        '{35, 35, 0, 0, 35}, // R3 top index
        '{10, 0, 0, 0, 0}    // R1 control processor address
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(input int ei, input int ep, input string tag);
        chk(gnt_valid === 1'b1, {tag, " valid"}, int'(gnt_valid), 1);
        chk(int'(gnt_in) == ei, {tag, " input"}, int'(gnt_in), ei);
        chk(int'(gnt_phys) == ep, {tag, " phys"}, int'(gnt_phys), ep);
    endtask

    task automatic chk_none(input string tag);
        chk(gnt_valid === 1'b0, tag, int'(gnt_valid), 0);
    endtask

    // drive at a negedge; the edge that follows captures it
    task automatic send(input int i, input int d, input bit p, input int k);
        req_valid[i] = 1'b1;
        req_dest[i]  = LW'(d);
        req_pin[i]   = p;
        req_key[i]   = KEY_W'(k);
        @(negedge clk);
        req_valid[i] = 1'b0;
    endtask

    task automatic release_port(input int p);
        rel[p] = 1'b1;
        @(negedge clk);
        rel[p] = 1'b0;
    endtask

    task automatic cfg(input int p, input int l);
        cfg_we = 1'b1; cfg_phys = PW'(p); cfg_log = LW'(l);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = '0; req_dest = '0; req_pin = '0; req_key = '0;
        rel = '0; cfg_we = 1'b0; cfg_phys = '0; cfg_log = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_none("R1 no connect after reset");
        chk(wait_v == '0, "R1 nobody waiting", int'(wait_v != '0), 0);

        cfg(9, 5);
        cfg(12, 5);

        // vector table
        for (int v = 0; v < 9; v++) begin
            send(VEC[v].in_i, VEC[v].dest, VEC[v].pin[0], VEC[v].key);
            @(negedge clk);
            chk_gnt(VEC[v].in_i, VEC[v].phys, $sformatf("R4/R5 vector %0d", v));
            @(negedge clk);
            chk_none("R3 connect is one cycle");
            release_port(VEC[v].phys);
        end

        // R4 / R5 / R6: members taken, pinned request waits
        send(1, 5, 1'b0, 0); @(negedge clk); chk_gnt(1, 5, "R4 first member");
        send(2, 5, 1'b0, 0); @(negedge clk); chk_gnt(2, 9, "R4 next free member");
        send(4, 5, 1'b1, 0); @(negedge clk);
        chk_none("R5 pinned waits for its member");
        chk(wait_v[4] === 1'b1, "R5 pinned still waiting", int'(wait_v[4]), 1);
        @(negedge clk);
        chk_none("R5 pinned ignores free member 12");
        release_port(5);
        @(negedge clk);
        chk_gnt(4, 5, "R6 release lets pinned connect");
        release_port(5);
        release_port(9);

        // R2 same-cycle numbering by input index, one port
        req_valid[20] = 1'b1; req_dest[20] = 6'd3; req_pin[20] = 1'b0;
        req_valid[8]  = 1'b1; req_dest[8]  = 6'd3; req_pin[8]  = 1'b0;
        req_valid[6]  = 1'b1; req_dest[6]  = 6'd3; req_pin[6]  = 1'b0;
        @(negedge clk);
        req_valid = '0;
        @(negedge clk); chk_gnt(6, 3, "R2 first number");
        @(negedge clk); chk_none("R6 port held without release");
        release_port(3); @(negedge clk); chk_gnt(8, 3, "R2 second number");
        release_port(3); @(negedge clk); chk_gnt(20, 3, "R2 third number");
        release_port(3);

        // R8 / R3 two destinations ready together
        req_valid[11] = 1'b1; req_dest[11] = 6'd7; req_pin[11] = 1'b0;
        req_valid[12] = 1'b1; req_dest[12] = 6'd4; req_pin[12] = 1'b0;
        @(negedge clk);
        req_valid = '0;
        @(negedge clk); chk_gnt(12, 4, "R8 lower logical wins");
        @(negedge clk); chk_gnt(11, 7, "R3 next connect with no gap");
        release_port(4);
        release_port(7);

        // R9 request on a waiting input is ignored
        send(1, 1, 1'b0, 0); @(negedge clk); chk_gnt(1, 1, "R9 setup");
        send(2, 1, 1'b0, 0);
        send(2, 6, 1'b0, 0);
        @(negedge clk);
        chk_none("R9 second request ignored");
        release_port(1);
        @(negedge clk); chk_gnt(2, 1, "R9 original request kept");
        @(negedge clk); chk_none("R9 nothing to port 6");
        chk(wait_v == '0, "R9 no stray waiter", int'(wait_v != '0), 0);
        release_port(1);

        // R7 protected writes
        cfg(0, 3);
        cfg(20, 0);
        send(9, 0, 1'b0, 0); @(negedge clk); chk_gnt(9, 0, "R7 logical 0 stays on port 0");
        release_port(0);
        send(9, 3, 1'b0, 0); @(negedge clk); chk_gnt(9, 3, "R7 port 0 not added to 3");
        release_port(3);
        send(9, 20, 1'b0, 0); @(negedge clk); chk_gnt(9, 20, "R7 port 20 kept its address");
        release_port(20);
        cfg(13, 30);
        send(9, 30, 1'b0, 0); @(negedge clk); chk_gnt(9, 13, "R7 write adds port 13 to 30");
        release_port(13);

        // R10 counters wrap
        for (int n = 0; n < 70; n++) begin
            send(n % 3, 30, 1'b0, 0);
            @(negedge clk);
            chk_gnt(n % 3, 13, $sformatf("R10 round trip %0d", n));
            release_port(13);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule